// File: doc/BRIEF.md
# Register Page Select Decoder

This block holds the register page that a serial host currently addresses and steers register reads and writes with it. There are three pages: the default configuration page, an extended page, and a nonvolatile-memory page. Serial protocol engines sit outside the block. Each engine hands over a finished command byte, a one-cycle valid strobe and an identifier that names the path it came from: the two-wire (I2C-style) command path or the JTAG-style instruction path.

The two paths use different code sets for the same page moves. Each path has one code that moves to a page and one code that returns to the default page. A return code is honoured from whatever page is current, so it does not have to match the page it is paired with. Only one host path is active at a time. Every strobe is consumed in the cycle it appears, so the command input has no ready signal and never applies back-pressure. A valid command changes the page output on the clock edge that samples the strobe.

Top module: `page_select`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `page_sel` is 2'b00 (default page). Extended is 2'b01, nonvolatile-memory is 2'b10, and 2'b11 never appears.
- R2: With `cmd_src`=0 (I2C-style path), a strobed code 8'h98 makes `page_sel` 2'b01 from any page.
- R3: With `cmd_src`=0, a strobed code 8'h9A makes `page_sel` 2'b10 from any page.
- R4: With `cmd_src`=0, a strobed 8'h99 or 8'h9B makes `page_sel` 2'b00 from any page.
- R5: With `cmd_src`=1 (JTAG-style path), a strobed 8'h09 makes `page_sel` 2'b01 and a strobed 8'h0B makes it 2'b10, from any page.
- R6: With `cmd_src`=1, a strobed 8'h0A or 8'h0C makes `page_sel` 2'b00 from any page.
- R7: A strobed code that is not a page code of its own path leaves `page_sel` unchanged. This includes a page code that belongs to the other path.
- R8: `page_sel` changes only on the rising edge that samples `cmd_valid` high, and its new value is visible right after that edge. With `cmd_valid` low it holds, whatever `cmd_code` and `cmd_src` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset to the default page |
| cmd_valid | input | 1 | One-cycle strobe: `cmd_code` holds a finished command |
| cmd_src | input | 1 | Source path: 0 = I2C-style, 1 = JTAG-style |
| cmd_code | input | CMD_W (8) | Command byte |
| page_sel | output | 2 | Current page: 00 default, 01 extended, 10 nonvolatile-memory |

## Verification
The assertions assume that `cmd_src` and `cmd_code` are known (not X) whenever `cmd_valid` is high. They also assume that exactly one path issues each strobe. The field on `cmd_src` names that path, so the assertions do not need to model two engines colliding. The bench drives every input from a single task at the falling edge, with defined values throughout. It also drives junk codes while `cmd_valid` is low, so the hold behaviour is checked against inputs that would change the page if they were strobed.

// File: rtl/page_select_pkg.sv
package page_select_pkg;
  typedef enum logic [1:0] {
    PG_BASE = 2'b00,
    PG_EXT  = 2'b01,
    PG_NVM  = 2'b10
  } page_e;

  typedef struct packed {
    logic  hit;
    page_e dest;
  } page_req_t;

  localparam int N_SRC = 2;
  localparam int SRC_TW = 0;   // two-wire command path
  localparam int SRC_JT = 1;   // JTAG-style instruction path

  // code sets: {select extended, return, select nvm, return}
  localparam logic [7:0] TW_EXT_GO  = 8'h98;
  localparam logic [7:0] TW_EXT_RET = 8'h99;
  localparam logic [7:0] TW_NVM_GO  = 8'h9A;
  localparam logic [7:0] TW_NVM_RET = 8'h9B;
  localparam logic [7:0] JT_EXT_GO  = 8'h09;
  localparam logic [7:0] JT_EXT_RET = 8'h0A;
  localparam logic [7:0] JT_NVM_GO  = 8'h0B;
  localparam logic [7:0] JT_NVM_RET = 8'h0C;
endpackage

// File: rtl/page_select_decode.sv
module page_select_decode
  import page_select_pkg::*;
#(
  parameter int CMD_W = 8,
  parameter logic [CMD_W-1:0] EXT_GO  = '0,
  parameter logic [CMD_W-1:0] EXT_RET = '0,
  parameter logic [CMD_W-1:0] NVM_GO  = '0,
  parameter logic [CMD_W-1:0] NVM_RET = '0
) (
  input  logic [CMD_W-1:0] code,
  output page_req_t        req
);
  always_comb begin
    req = '{hit: 1'b0, dest: PG_BASE};
    if (code == EXT_GO)                           req = '{hit: 1'b1, dest: PG_EXT};
    else if (code == NVM_GO)                      req = '{hit: 1'b1, dest: PG_NVM};
    else if (code == EXT_RET || code == NVM_RET)  req = '{hit: 1'b1, dest: PG_BASE};
  end
endmodule

// File: rtl/page_select_route.sv
module page_select_route
  import page_select_pkg::*;
(
  input  logic      valid,
  input  logic      src,
  input  page_req_t req_by_src [N_SRC],
  output page_req_t upd
);
  page_req_t pick;
  always_comb begin
    pick = req_by_src[src];
    upd.hit  = valid & pick.hit;
    upd.dest = pick.dest;
  end
endmodule

// File: rtl/page_select_state.sv
module page_select_state
  import page_select_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  page_req_t upd,
  output page_e     cur
);
  always_ff @(posedge clk) begin
    if (!rst_n)       cur <= PG_BASE;
    else if (upd.hit) cur <= upd.dest;
  end
endmodule

// File: rtl/page_select.sv
module page_select
  import page_select_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_src,
  input  logic [CMD_W-1:0] cmd_code,
  output logic [1:0]       page_sel
);
  page_req_t req_by_src [N_SRC];
  page_req_t upd;
  page_e     cur;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    localparam logic [CMD_W-1:0] C_EG = CMD_W'(g == SRC_TW ? TW_EXT_GO  : JT_EXT_GO);
    localparam logic [CMD_W-1:0] C_ER = CMD_W'(g == SRC_TW ? TW_EXT_RET : JT_EXT_RET);
    localparam logic [CMD_W-1:0] C_NG = CMD_W'(g == SRC_TW ? TW_NVM_GO  : JT_NVM_GO);
    localparam logic [CMD_W-1:0] C_NR = CMD_W'(g == SRC_TW ? TW_NVM_RET : JT_NVM_RET);
    page_select_decode #(
      .CMD_W(CMD_W), .EXT_GO(C_EG), .EXT_RET(C_ER), .NVM_GO(C_NG), .NVM_RET(C_NR)
    ) u_dec (
      .code(cmd_code),
      .req (req_by_src[g])
    );
  end

  page_select_route u_route (
    .valid     (cmd_valid),
    .src       (cmd_src),
    .req_by_src(req_by_src),
    .upd       (upd)
  );

  page_select_state u_state (
    .clk  (clk),
    .rst_n(rst_n),
    .upd  (upd),
    .cur  (cur)
  );

  assign page_sel = cur;
endmodule

// File: rtl/page_select_chk.sv
module page_select_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_src,
  input logic [7:0] cmd_code,
  input logic [1:0] page_sel
);
  logic tw_known, jt_known, known;
  assign tw_known = cmd_code inside {8'h98, 8'h99, 8'h9A, 8'h9B};
  assign jt_known = cmd_code inside {8'h09, 8'h0A, 8'h0B, 8'h0C};
  assign known    = cmd_src ? jt_known : tw_known;

  // R1
  reset_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> page_sel == 2'b00);
  // R1
  legal_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_sel != 2'b11);
  // R2
  tw_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_src && cmd_code == 8'h98) |=> page_sel == 2'b01);
  // R3
  tw_nvm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_src && cmd_code == 8'h9A) |=> page_sel == 2'b10);
  // R4
  tw_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_src && (cmd_code == 8'h99 || cmd_code == 8'h9B)) |=> page_sel == 2'b00);
  // R5
  jt_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_src && cmd_code == 8'h09) |=> page_sel == 2'b01);
  // R5
  jt_nvm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_src && cmd_code == 8'h0B) |=> page_sel == 2'b10);
  // R6
  jt_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_src && (cmd_code == 8'h0A || cmd_code == 8'h0C)) |=> page_sel == 2'b00);
  // R7
  unknown_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !known) |=> $stable(page_sel));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(page_sel));
endmodule

bind page_select page_select_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_valid(cmd_valid),
  .cmd_src  (cmd_src),
  .cmd_code (cmd_code),
  .page_sel (page_sel)
);

// File: tb/sim_page_select.sv
`timescale 1ns/1ps
module sim_page_select;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_src = 1'b0;
  logic [7:0] cmd_code = 8'h00;
  logic [1:0] page_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  page_select u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .cmd_src(cmd_src), .cmd_code(cmd_code), .page_sel(page_sel)
  );

  // {src, code, expected page after strobe}
  localparam int NV = 20;
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 8'h98, 2'd1},  // R2
    {1'b0, 8'h99, 2'd0},  // R4
    {1'b0, 8'h9A, 2'd2},  // R3
    {1'b0, 8'h9B, 2'd0},  // R4
    {1'b1, 8'h09, 2'd1},  // R5
    {1'b1, 8'h0C, 2'd0},  // R6 cross return
    {1'b1, 8'h0B, 2'd2},  // R5
    {1'b1, 8'h0A, 2'd0},  // R6 cross return
    {1'b0, 8'h9A, 2'd2},  // R3
    {1'b0, 8'h99, 2'd0},  // R4 cross return
    {1'b1, 8'h09, 2'd1},  // R5
    {1'b0, 8'h09, 2'd1},  // R7 other path's code
    {1'b1, 8'h98, 2'd1},  // R7 other path's code
    {1'b0, 8'h00, 2'd1},  // R7
    {1'b1, 8'hFF, 2'd1},  // R7
    {1'b1, 8'h0D, 2'd1},  // R7
    {1'b0, 8'h9C, 2'd1},  // R7
    {1'b0, 8'h9A, 2'd2},  // R3 ext to nvm directly
    {1'b1, 8'h09, 2'd1},  // R5 nvm to ext directly
    {1'b0, 8'h9B, 2'd0}   // R4
  };

  function automatic string tag_of(input logic s, input logic [7:0] c);
    if (!s && c == 8'h98) return "R2";
    if (!s && c == 8'h9A) return "R3";
    if (!s && (c == 8'h99 || c == 8'h9B)) return "R4";
    if (s && (c == 8'h09 || c == 8'h0B)) return "R5";
    if (s && (c == 8'h0A || c == 8'h0C)) return "R6";
    return "R7";
  endfunction

  task automatic check(input string req, input logic [1:0] exp);
    checks++;
    if (page_sel !== exp) begin
      errors++;
      $display("FAIL %s page_sel=%0d expected=%0d", req, page_sel, exp);
    end
  endtask

  task automatic strobe(input logic s, input logic [7:0] c);
    cmd_valid = 1'b1; cmd_src = s; cmd_code = c;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = 8'h00;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 2'd0);                       // during reset
    strobe(1'b0, 8'h98);                     // strobed while in reset
    check("R1", 2'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 2'd0);

    for (int i = 0; i < NV; i++) begin
      strobe(VEC[i][10], VEC[i][9:2]);
      check(tag_of(VEC[i][10], VEC[i][9:2]), VEC[i][1:0]);
    end

    // R8: page codes present but not strobed
    cmd_src = 1'b0; cmd_code = 8'h9A;
    repeat (3) @(negedge clk);
    check("R8", 2'd0);
    cmd_src = 1'b1; cmd_code = 8'h09;
    repeat (3) @(negedge clk);
    check("R8", 2'd0);

    // R8: back-to-back strobes, one-cycle update each
    cmd_valid = 1'b1; cmd_src = 1'b0; cmd_code = 8'h98;
    @(negedge clk);
    check("R8", 2'd1);
    cmd_code = 8'h9A;
    @(negedge clk);
    check("R8", 2'd2);
    cmd_valid = 1'b0; cmd_code = 8'h00;
    @(negedge clk);
    check("R8", 2'd2);

    // R1: reset from the nvm page
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", 2'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 2'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule